// File: doc/BRIEF.md
# Address-Transition Page Read Sequencer

This block sequences a flash array read from the address alone. It watches the read address on every tick of a timing clock. When an address bit above the in-page word field changes, it starts a fixed chain of one-cycle enables: a master pulse, then wordline select, then bitline connection to the sense path, then the first and second stages of a dynamic latching sense amplifier. The four words sensed on the second latch stage are captured into a page register, and the addressed word is presented with a data-valid flag.

While the page stays latched, a change confined to the two word-select bits does not fire the enable chain. Only the page register's output multiplexer moves, and data-valid returns one cycle later. A page therefore costs four cycles for its first word and one cycle for each further word. At a 10 ns clock this is 40 ns plus three times 10 ns, about 18 ns per word on average.

The analog sense amplifier is not modelled. Its resolved output for a whole page is a parallel data input that the block samples at the end of the chain. Dropping the read enable parks the sequencer. Raising it again starts a full read of whatever address is present.

Top module: `atd_page_read_seq`

## Requirements
- R1: At a clock edge where the read enable is high and was high at the previous edge, an upper address bit (above bit 1) that differs from its value at the previous edge makes `mst_pulse` high for the next cycle. A rising read enable does the same.
- R2: After `mst_pulse`, unless aborted, the enables follow in a fixed order, one cycle each: `wl_en`, `bl_en`, `sa1_en`, `sa2_en`. No two of the five are ever high together.
- R3: For a full read, `data_valid` rises at the fourth clock edge after the detecting edge, together with `sa2_en`. At that edge the page register loads `sense_data`, where word i occupies bits `[16*i+15:16*i]`.
- R4: While data is valid, a change in only address bits [1:0] drops `data_valid` for exactly one cycle. It then presents the newly addressed word, with no stage enable firing. Repeated changes during that cycle extend it.
- R5: A change in only address bits [1:0] during the enable chain does not restart or lengthen it. The word delivered at the end of the chain is the one selected by the latest low bits.
- R6: With the read enable low, the next edge forces `data_valid` and all stage enables low, and they stay low whatever the address does.
- R7: During and right after reset, all stage enables and `data_valid` are low.
- R8: An upper address change at any point, including mid-chain or together with a low-bit change, aborts the current access. A new full read of the new address starts.
- R9: While data is valid and the address and enable are held, `data_valid` stays high and no stage enable fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock for pulse generation (10 ns nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Combined chip/output read enable, active high |
| addr | input | 20 | Word read address; bits [1:0] select the word in the page |
| sense_data | input | 64 | Resolved sense amplifier outputs for the four page words |
| mst_pulse | output | 1 | Master pulse opening a read cycle |
| wl_en | output | 1 | Wordline select enable |
| bl_en | output | 1 | Bitline-to-sense-path connect enable |
| sa1_en | output | 1 | First sense latch stage enable |
| sa2_en | output | 1 | Second sense latch stage enable |
| word_sel | output | 2 | Word of the page currently presented |
| data_out | output | 16 | Selected page word |
| data_valid | output | 1 | The word on `data_out` is valid for the current address |

## Verification
The hardest cases to reach from the ports are address changes that land on a chosen stage of the chain: a low-bit change inside the wordline cycle, or a second upper change in the middle of the chain. The stimulus drives every address on the falling edge and counts rising edges from the detecting edge. This lets it place the second change in a known stage and predict the remaining latency exactly: two cycles for the mid-chain low-bit change, a fresh four for the restart. A vector table walks mixed page and full accesses, including one that changes upper and lower bits together.

// File: rtl/atd_seq_pkg.sv
package atd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MST   = 3'd1,
        ST_WL    = 3'd2,
        ST_BL    = 3'd3,
        ST_SA1   = 3'd4,
        ST_SA2   = 3'd5,
        ST_READY = 3'd6,
        ST_STEP  = 3'd7
    } rd_state_e;

    typedef struct packed {
        rd_state_e state;
    } ctrl_regs_t;

endpackage

// File: rtl/atd_detect.sv
module atd_detect #(
    parameter int ADDR_W = 20,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              start_evt,
    output logic              hi_evt,
    output logic              lo_evt
);

    localparam int HI_W = ADDR_W - SEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              en;
    } atd_regs_t;

    atd_regs_t d, q;

    logic [HI_W-1:0]  hi_now, hi_old;
    logic [SEL_W-1:0] lo_now, lo_old;

    assign hi_now = addr[ADDR_W-1:SEL_W];
    assign hi_old = q.addr[ADDR_W-1:SEL_W];
    assign lo_now = addr[SEL_W-1:0];
    assign lo_old = q.addr[SEL_W-1:0];

    always_comb begin
        d    = q;
        d.en = en;
        if (en) begin
            d.addr = addr;
        end
        start_evt = en && !q.en;
        hi_evt    = en && q.en && (hi_now != hi_old);
        lo_evt    = en && q.en && (lo_now != lo_old);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> (!hi_evt && !lo_evt)); // R1

endmodule

// File: rtl/rd_pulse_ctrl.sv
module rd_pulse_ctrl
    import atd_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_evt,
    input  logic hi_evt,
    input  logic lo_evt,
    output logic mst_pulse,
    output logic wl_en,
    output logic bl_en,
    output logic sa1_en,
    output logic sa2_en,
    output logic data_valid,
    output logic page_load
);

    ctrl_regs_t d, q;

    always_comb begin
        d = q;
        if (!en) begin
            d.state = ST_IDLE;
        end else if (start_evt || hi_evt) begin
            d.state = ST_MST;
        end else begin
            unique case (q.state)
                ST_IDLE:  d.state = ST_IDLE;
                ST_MST:   d.state = ST_WL;
                ST_WL:    d.state = ST_BL;
                ST_BL:    d.state = ST_SA1;
                ST_SA1:   d.state = ST_SA2;
                ST_SA2:   d.state = lo_evt ? ST_STEP : ST_READY;
                ST_READY: d.state = lo_evt ? ST_STEP : ST_READY;
                ST_STEP:  d.state = lo_evt ? ST_STEP : ST_READY;
                default:  d.state = ST_IDLE;
            endcase
        end
        page_load = (d.state == ST_SA2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mst_pulse  = (q.state == ST_MST);
    assign wl_en      = (q.state == ST_WL);
    assign bl_en      = (q.state == ST_BL);
    assign sa1_en     = (q.state == ST_SA1);
    assign sa2_en     = (q.state == ST_SA2);
    assign data_valid = (q.state == ST_SA2) || (q.state == ST_READY);

    AST_STEP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STEP && en && !lo_evt && !hi_evt) |=> data_valid); // R4

endmodule

// File: rtl/page_latch.sv
module page_latch #(
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4,
    parameter int SEL_W      = $clog2(PAGE_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         load,
    input  logic [SEL_W-1:0]             addr_lo,
    input  logic [PAGE_WORDS*DATA_W-1:0] sense_data,
    output logic [SEL_W-1:0]             sel,
    output logic [DATA_W-1:0]            data_out
);

    typedef struct packed {
        logic [PAGE_WORDS-1:0][DATA_W-1:0] page;
        logic [SEL_W-1:0]                  sel;
    } page_regs_t;

    page_regs_t d, q;
    logic [PAGE_WORDS-1:0][DATA_W-1:0] sense_words;

    for (genvar gi = 0; gi < PAGE_WORDS; gi++) begin : g_unpack
        assign sense_words[gi] = sense_data[gi*DATA_W +: DATA_W];
    end

    always_comb begin
        d = q;
        if (en) begin
            d.sel = addr_lo;
        end
        if (load) begin
            d.page = sense_words;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sel      = q.sel;
    assign data_out = q.page[q.sel];

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q.page)); // R4

endmodule

// File: rtl/atd_page_read_seq.sv
module atd_page_read_seq #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [PAGE_WORDS*DATA_W-1:0] sense_data,
    output logic                         mst_pulse,
    output logic                         wl_en,
    output logic                         bl_en,
    output logic                         sa1_en,
    output logic                         sa2_en,
    output logic [$clog2(PAGE_WORDS)-1:0] word_sel,
    output logic [DATA_W-1:0]            data_out,
    output logic                         data_valid
);

    localparam int SEL_W = $clog2(PAGE_WORDS);

    logic start_evt, hi_evt, lo_evt, page_load;

    atd_detect #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_atd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rd_en),
        .addr      (addr),
        .start_evt (start_evt),
        .hi_evt    (hi_evt),
        .lo_evt    (lo_evt)
    );

    rd_pulse_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rd_en),
        .start_evt  (start_evt),
        .hi_evt     (hi_evt),
        .lo_evt     (lo_evt),
        .mst_pulse  (mst_pulse),
        .wl_en      (wl_en),
        .bl_en      (bl_en),
        .sa1_en     (sa1_en),
        .sa2_en     (sa2_en),
        .data_valid (data_valid),
        .page_load  (page_load)
    );

    page_latch #(
        .DATA_W     (DATA_W),
        .PAGE_WORDS (PAGE_WORDS),
        .SEL_W      (SEL_W)
    ) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rd_en),
        .load       (page_load),
        .addr_lo    (addr[SEL_W-1:0]),
        .sense_data (sense_data),
        .sel        (word_sel),
        .data_out   (data_out)
    );

    AST_MST_ON_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hi_evt || start_evt)) |=> mst_pulse); // R1

    AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mst_pulse, wl_en, bl_en, sa1_en, sa2_en})); // R2

    AST_CHAIN_WL: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_pulse && rd_en && !hi_evt) |=> wl_en); // R2

    AST_CHAIN_BL: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_en && rd_en && !hi_evt) |=> bl_en); // R5

    AST_CHAIN_SA1: assert property (@(posedge clk) disable iff (!rst_n)
        (bl_en && rd_en && !hi_evt) |=> sa1_en); // R2

    AST_FIRST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sa1_en && rd_en && !hi_evt) |=> (sa2_en && data_valid)); // R3

    AST_PAGE_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && rd_en && lo_evt && !hi_evt) |=> (!data_valid && !mst_pulse)); // R4

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!data_valid && !mst_pulse && !wl_en && !sa2_en)); // R6

    AST_RESTART_ON_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hi_evt && lo_evt) |=> (mst_pulse && !data_valid)); // R8

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && rd_en && !lo_evt && !hi_evt) |=> (data_valid && !mst_pulse)); // R9

endmodule

// File: tb/sim_atd_page_read_seq.sv
module sim_atd_page_read_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en;
    logic [19:0] addr;
    logic [63:0] sense_data;
    logic        mst_pulse, wl_en, bl_en, sa1_en, sa2_en, data_valid;
    logic [1:0]  word_sel;
    logic [15:0] data_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // Sense model: word i of the page with upper bits u is {i[1:0], u[13:0]}
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            sense_data[i*16 +: 16] = {i[1:0], addr[15:2]};
        end
    end

    atd_page_read_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr       (addr),
        .sense_data (sense_data),
        .mst_pulse  (mst_pulse),
        .wl_en      (wl_en),
        .bl_en      (bl_en),
        .sa1_en     (sa1_en),
        .sa2_en     (sa2_en),
        .word_sel   (word_sel),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    function automatic logic [15:0] exp_word(input logic [19:0] a);
        return {a[1:0], a[15:2]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then count edges after the detecting edge until valid.
    task automatic access(input logic [19:0] a, output int lat, output int msts);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        msts = int'(mst_pulse);
        lat  = 0;
        while (!data_valid && lat < 10) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            msts += int'(mst_pulse);
        end
    endtask

    // {page-only flag, address}
    localparam logic [20:0] VEC [12] = '{
        {1'b0, 20'h12340}, {1'b1, 20'h12341}, {1'b1, 20'h12343}, {1'b1, 20'h12342},
        {1'b1, 20'h12340}, {1'b0, 20'hABCD7}, {1'b1, 20'hABCD4}, {1'b0, 20'h00005},
        {1'b1, 20'h00006}, {1'b0, 20'hFFFFF}, {1'b1, 20'hFFFFC}, {1'b0, 20'h7FFFD}
    };

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual %0d expected < 100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int lat, msts;
        logic [4:0] stg;
        rst_n = 1'b0;
        rd_en = 1'b0;
        addr  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 stages", {mst_pulse, wl_en, bl_en, sa1_en, sa2_en}, 0);
        check("R7 valid", data_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release", {data_valid, mst_pulse}, 0);

        // R1: rising enable starts a full read
        access(20'h00000, lat, msts);
        check("R1 enable start latency", lat, 4);
        check("R1 enable start master", msts, 1);
        check("R3 first word", data_out, exp_word(20'h00000));

        // Vector walk: R3 full reads, R4 in-page reads, R8 combined change
        foreach (VEC[i]) begin
            access(VEC[i][19:0], lat, msts);
            if (VEC[i][20]) begin
                check("R4 page latency", lat, 1);
                check("R4 no master", msts, 0);
                check("R4 page word", data_out, exp_word(VEC[i][19:0]));
            end else begin
                check("R3 full latency", lat, 4);
                check("R8 one master", msts, 1);
                check("R3 full word", data_out, exp_word(VEC[i][19:0]));
            end
        end

        // R2: stage order
        @(negedge clk);
        addr = 20'h55550;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            stg = {mst_pulse, wl_en, bl_en, sa1_en, sa2_en};
            check("R2 stage order", stg, 5'b10000 >> k);
        end
        check("R3 valid with sa2", data_valid, 1);

        // R9: hold keeps data valid, no pulses
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9 hold", {data_valid, mst_pulse, wl_en, sa2_en}, 4'b1000);
        end

        // R8: restart in the wordline stage
        @(negedge clk);
        addr = 20'h22220;
        @(posedge clk);
        @(posedge clk);
        access(20'h33331, lat, msts);
        check("R8 restart latency", lat, 4);
        check("R8 restart word", data_out, exp_word(20'h33331));

        // R5: low-bit change in the wordline stage
        @(negedge clk);
        addr = 20'h44440;
        @(posedge clk);
        @(posedge clk);
        access(20'h44443, lat, msts);
        check("R5 chain not lengthened", lat, 2);
        check("R5 no restart", msts, 0);
        check("R5 latest word", data_out, exp_word(20'h44443));

        // R4: back-to-back low changes extend the gap
        @(negedge clk);
        addr = 20'h44441;
        @(posedge clk);
        access(20'h44442, lat, msts);
        check("R4 repeated change latency", lat, 1);
        check("R4 repeated change word", data_out, exp_word(20'h44442));

        // R6: disable parks the sequencer
        @(negedge clk);
        rd_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 valid off", data_valid, 0);
        addr = 20'h99990;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R6 quiet", {data_valid, mst_pulse, wl_en, bl_en, sa1_en, sa2_en}, 0);
        end
        access(20'h99991, lat, msts);
        check("R1 re-enable latency", lat, 4);
        check("R1 re-enable word", data_out, exp_word(20'h99991));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule